// File: doc/BRIEF.md
# DMA Interrupt Coalescing Controller

This block produces the interrupt of one scatter-gather DMA channel. Instead of interrupting on every finished descriptor, it counts completions down from a programmable threshold. It raises a completion flag only when that count runs out. A second mechanism covers traffic that stops part-way through a batch. A delay timer, clocked by a divided tick, is restarted by every completion. If no further completion arrives before the timer runs down, it raises a delay flag and re-arms the counter. A third flag records an error reported by the engine.

The three flags are sticky in the status word at bits 14:12 and are cleared by writing ones to them. Each flag reaches the single level interrupt output only when the control bit at the same position is set. The engine supplies a one-cycle completion pulse and a one-cycle error pulse. Software supplies full-word writes to the control and status words. Control readback replaces the programmed threshold and delay fields with the live counter and timer values. There is no data stream at this block's edge, so every pin is a plain control or status signal and none of them takes back-pressure.

Top module: `dma_irq_coalescer`

## Requirements
- R1: After reset, control readback is 0x0001_0000: counter 1, timer 0, low half 0. Status readback is 0 and `irq_o` is low.
- R2: A control write stores the whole word. Bits 15:0 read back as written. Readback bits 23:16 show the live counter and bits 31:24 show the live timer, not the written fields.
- R3: A completion decrements the counter. If the counter is 1 or 0 at that completion, the completion flag (status bit 12) is set and the counter reloads from the threshold (control bits 23:16), so a threshold of 0 acts like 1.
- R4: A control write with bit 0 set loads the counter from the threshold in that written word. In the same cycle it overrides any completion, which then neither decrements the counter nor sets bit 12.
- R5: A completion while the stored delay field (control bits 31:24) is nonzero loads the timer with that delay and restarts the prescaler. With a delay of 0, a completion leaves the timer alone.
- R6: The timer drops by one on each prescaler tick, one every PRESCALE cycles, and stays at 0. The tick that takes it from 1 to 0 is an expiry: it sets the delay flag (status bit 13) and, if no completion or load arrives in that cycle, reloads the counter from the threshold.
- R7: When a completion and an expiry fall in the same cycle, the timer restarts from the delay, the counter follows the completion, and the delay flag is still set.
- R8: An error pulse sets the error flag (status bit 14).
- R9: In a status write, ones in bits 14:12 clear those flags. A flag event in the same cycle takes precedence over the clear. All other status bits are stored as written and read back.
- R10: `irq_o` is high exactly when some status bit in 14:12 is set together with the control bit at the same position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| done_i | input | 1 | One-cycle descriptor completion pulse |
| fault_i | input | 1 | One-cycle error pulse |
| ctrl_wr_i | input | 1 | Control word write strobe |
| ctrl_wdata_i | input | 32 | Control word write data |
| stat_wr_i | input | 1 | Status word write strobe |
| stat_wdata_i | input | 32 | Status word write data |
| ctrl_rdata_o | output | 32 | Control readback with live counter and timer |
| stat_rdata_o | output | 32 | Status readback with the pending flags |
| irq_o | output | 1 | Level interrupt |

## Verification
The assertions check on every cycle how the counter steps after a completion or a load. They also check that the timer restarts, counts down and holds at zero as specified, that the prescaler resets on restart, and that each flag is sticky until a one is written to it. Some behaviour only the bench's scenarios can show. This covers the ordering between a completion and a timer expiry in the same cycle, the precedence of a flag event over a clear, and the zero threshold. It also covers how masking affects the interrupt. The bench checks these against a cycle-by-cycle model of the status and control readback.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned CNT_W    = 8;
  localparam int unsigned TMR_W    = 8;
  localparam int unsigned NFLAG    = 3;
  localparam int unsigned FLAG_LSB = 12;
  localparam int unsigned FLAG_MSB = FLAG_LSB + NFLAG - 1;
  localparam int unsigned THR_LSB  = 16;
  localparam int unsigned THR_MSB  = THR_LSB + CNT_W - 1;
  localparam int unsigned DLY_LSB  = THR_MSB + 1;
  localparam int unsigned DLY_MSB  = DLY_LSB + TMR_W - 1;
  localparam int unsigned RUN_BIT  = 0;

  typedef enum int unsigned {
    FL_DONE  = 0,
    FL_DELAY = 1,
    FL_ERR   = 2
  } flag_idx_e;
endpackage

// File: rtl/irqc_prescaler.sv
module irqc_prescaler #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int unsigned PSC_W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [PSC_W-1:0] LAST = PSC_W'(DIV - 1);

  logic [PSC_W-1:0] phase_q;

  assign tick = (phase_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (restart || tick) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_q + PSC_W'(1);
    end
  end

  a_r5_psc_restart: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (phase_q == '0));

  a_r6_psc_range: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q <= LAST);
endmodule

// File: rtl/irqc_delay_timer.sv
module irqc_delay_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic [W-1:0] start_val,
  input  logic         tick,
  output logic [W-1:0] count,
  output logic         expire
);
  logic [W-1:0] cnt_q;

  assign count  = cnt_q;
  assign expire = tick && (cnt_q == W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart) begin
      cnt_q <= start_val;
    end else if (tick && (cnt_q != '0)) begin
      cnt_q <= cnt_q - W'(1);
    end
  end

  a_r5_timer_restart: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == $past(start_val)));

  a_r6_timer_holds_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !restart) |=> (cnt_q == '0));

  a_r6_timer_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !restart && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - W'(1)));

  a_r6_timer_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !restart) |=> $stable(cnt_q));
endmodule

// File: rtl/irqc_threshold_counter.sv
module irqc_threshold_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         done,
  input  logic         rearm,
  input  logic [W-1:0] thr,
  output logic [W-1:0] count,
  output logic         fire
);
  logic [W-1:0] cnt_q;
  logic         last;

  assign last  = (cnt_q <= W'(1));
  assign fire  = done && !load && last;
  assign count = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= W'(1);
    end else if (load) begin
      cnt_q <= load_val;
    end else if (done) begin
      cnt_q <= last ? thr : (cnt_q - W'(1));
    end else if (rearm) begin
      cnt_q <= thr;
    end
  end

  a_r4_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(load_val)));

  a_r3_reload_on_fire: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !load && cnt_q <= W'(1)) |=> (cnt_q == $past(thr)));

  a_r3_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !load && cnt_q > W'(1)) |=> (cnt_q == $past(cnt_q) - W'(1)));

  a_r6_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    (rearm && !done && !load) |=> (cnt_q == $past(thr)));
endmodule

// File: rtl/dma_irq_coalescer.sv
module dma_irq_coalescer
  import irqc_pkg::*;
#(
  parameter int unsigned PRESCALE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done_i,
  input  logic              fault_i,
  input  logic              ctrl_wr_i,
  input  logic [WORD_W-1:0] ctrl_wdata_i,
  input  logic              stat_wr_i,
  input  logic [WORD_W-1:0] stat_wdata_i,
  output logic [WORD_W-1:0] ctrl_rdata_o,
  output logic [WORD_W-1:0] stat_rdata_o,
  output logic              irq_o
);
  localparam logic [WORD_W-1:0] CTRL_RST = WORD_W'(1) << THR_LSB;
  localparam int unsigned HI_W = WORD_W - FLAG_MSB - 1;

  logic [WORD_W-1:0]   ctrl_q;
  logic [HI_W-1:0]     stat_hi_q;
  logic [FLAG_LSB-1:0] stat_lo_q;
  logic [NFLAG-1:0]    flags_q;
  logic [NFLAG-1:0]    flag_set;
  logic [NFLAG-1:0]    flag_clr;
  logic [NFLAG-1:0]    mask;

  logic [CNT_W-1:0] thr;
  logic [TMR_W-1:0] dly;
  logic [CNT_W-1:0] cnt;
  logic [TMR_W-1:0] tmr;
  logic             tick;
  logic             restart;
  logic             expire;
  logic             fire;
  logic             load;

  assign thr     = ctrl_q[THR_MSB:THR_LSB];
  assign dly     = ctrl_q[DLY_MSB:DLY_LSB];
  assign mask    = ctrl_q[FLAG_MSB:FLAG_LSB];
  assign restart = done_i && (dly != '0);
  assign load    = ctrl_wr_i && ctrl_wdata_i[RUN_BIT];

  irqc_prescaler #(.DIV(PRESCALE)) u_psc (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .tick    (tick)
  );

  irqc_delay_timer #(.W(TMR_W)) u_tmr (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (restart),
    .start_val (dly),
    .tick      (tick),
    .count     (tmr),
    .expire    (expire)
  );

  irqc_threshold_counter #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (ctrl_wdata_i[THR_MSB:THR_LSB]),
    .done     (done_i),
    .rearm    (expire),
    .thr      (thr),
    .count    (cnt),
    .fire     (fire)
  );

  always_comb begin
    flag_set           = '0;
    flag_set[FL_DONE]  = fire;
    flag_set[FL_DELAY] = expire;
    flag_set[FL_ERR]   = fault_i;
    flag_clr           = stat_wr_i ? stat_wdata_i[FLAG_MSB:FLAG_LSB] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= CTRL_RST;
      stat_hi_q <= '0;
      stat_lo_q <= '0;
      flags_q   <= '0;
    end else begin
      if (ctrl_wr_i) begin
        ctrl_q <= ctrl_wdata_i;
      end
      if (stat_wr_i) begin
        stat_hi_q <= stat_wdata_i[WORD_W-1:FLAG_MSB+1];
        stat_lo_q <= stat_wdata_i[FLAG_LSB-1:0];
      end
      flags_q <= (flags_q & ~flag_clr) | flag_set;
    end
  end

  assign ctrl_rdata_o = {tmr, cnt, ctrl_q[THR_LSB-1:0]};
  assign stat_rdata_o = {stat_hi_q, flags_q, stat_lo_q};
  assign irq_o        = |(flags_q & mask);

  generate
    for (genvar i = 0; i < NFLAG; i++) begin : g_flag_chk
      a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q[i] && !(stat_wr_i && stat_wdata_i[FLAG_LSB+i])) |=> flags_q[i]);
      a_r9_event_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        flag_set[i] |=> stat_rdata_o[FLAG_LSB+i]);
    end
  endgenerate

  a_r8_error_flag: assert property (@(posedge clk) disable iff (!rst_n)
    fault_i |=> stat_rdata_o[FLAG_LSB+FL_ERR]);

  a_r9_clear_done: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr_i && stat_wdata_i[FLAG_LSB] && !fire) |=> !stat_rdata_o[FLAG_LSB]);

  a_r2_low_half: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr_i |=> (ctrl_rdata_o[THR_LSB-1:0] == $past(ctrl_wdata_i[THR_LSB-1:0])));

  a_r10_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (stat_rdata_o[FLAG_MSB:FLAG_LSB] != '0));
endmodule

// File: tb/dma_irq_coalescer_test.sv
`timescale 1ns/1ps
module dma_irq_coalescer_test;
  localparam int P = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        done_i = 1'b0, fault_i = 1'b0;
  logic        ctrl_wr_i = 1'b0, stat_wr_i = 1'b0;
  logic [31:0] ctrl_wdata_i = '0, stat_wdata_i = '0;
  logic [31:0] ctrl_rdata_o, stat_rdata_o;
  logic        irq_o;

  int n_chk = 0, n_bad = 0, cycles = 0, coinc_seen = 0;

  logic [31:0] m_ctrl, m_stat;
  logic [2:0]  m_flags;
  int          m_cnt, m_tmr, m_psc;
  bit          m_load, m_coinc;

  always #4 clk = ~clk;

  dma_irq_coalescer #(.PRESCALE(P)) uut (
    .clk(clk), .rst_n(rst_n), .done_i(done_i), .fault_i(fault_i),
    .ctrl_wr_i(ctrl_wr_i), .ctrl_wdata_i(ctrl_wdata_i),
    .stat_wr_i(stat_wr_i), .stat_wdata_i(stat_wdata_i),
    .ctrl_rdata_o(ctrl_rdata_o), .stat_rdata_o(stat_rdata_o), .irq_o(irq_o));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", req, cycles, act, exp);
    end
  endtask

  // behavioural reference, updated on each rising edge
  always @(posedge clk) begin
    bit tick, exp_ev, ioc;
    int thr, dly;
    logic [2:0] clr;
    cycles++;
    if (!rst_n) begin
      m_ctrl = 32'h0001_0000; m_stat = '0; m_flags = '0;
      m_cnt = 1; m_tmr = 0; m_psc = 0; m_load = 0; m_coinc = 0;
    end else begin
      tick   = (m_psc == P - 1);
      exp_ev = tick && (m_tmr == 1);
      thr    = m_ctrl[23:16];
      dly    = m_ctrl[31:24];
      ioc    = 0;
      m_load = ctrl_wr_i && ctrl_wdata_i[0];
      m_coinc = done_i && exp_ev;
      if (m_coinc) coinc_seen++;
      if (m_load) m_cnt = ctrl_wdata_i[23:16];
      else if (done_i) begin
        if (m_cnt <= 1) begin ioc = 1; m_cnt = thr; end
        else m_cnt = m_cnt - 1;
      end else if (exp_ev) m_cnt = thr;
      if (done_i && dly != 0) begin
        m_tmr = dly; m_psc = 0;
      end else begin
        if (tick && m_tmr > 0) m_tmr = m_tmr - 1;
        m_psc = tick ? 0 : m_psc + 1;
      end
      clr = stat_wr_i ? stat_wdata_i[14:12] : 3'b000;
      m_flags = (m_flags & ~clr) | {fault_i, exp_ev, ioc};
      if (ctrl_wr_i) m_ctrl = ctrl_wdata_i;
      if (stat_wr_i) m_stat = stat_wdata_i & ~32'h0000_7000;
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      check("R2 low half", {16'h0, ctrl_rdata_o[15:0]}, {16'h0, m_ctrl[15:0]});
      check(m_load ? "R4 counter load" : "R3 counter", {24'h0, ctrl_rdata_o[23:16]}, 32'(m_cnt[7:0]));
      check(m_coinc ? "R7 timer restart" : "R5 timer", {24'h0, ctrl_rdata_o[31:24]}, 32'(m_tmr[7:0]));
      check("R3 done flag", {31'h0, stat_rdata_o[12]}, {31'h0, m_flags[0]});
      check(m_coinc ? "R7 delay flag" : "R6 delay flag", {31'h0, stat_rdata_o[13]}, {31'h0, m_flags[1]});
      check("R8 error flag", {31'h0, stat_rdata_o[14]}, {31'h0, m_flags[2]});
      check("R9 stored bits", stat_rdata_o & ~32'h7000, m_stat);
      check("R10 irq", {31'h0, irq_o}, {31'h0, |(m_flags & m_ctrl[14:12])});
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive(input bit d, input bit f, input bit cw, input logic [31:0] cd,
                       input bit sw, input logic [31:0] sd);
    @(negedge clk);
    done_i = d; fault_i = f; ctrl_wr_i = cw; ctrl_wdata_i = cd;
    stat_wr_i = sw; stat_wdata_i = sd;
    @(negedge clk);
    done_i = 0; fault_i = 0; ctrl_wr_i = 0; stat_wr_i = 0;
  endtask

  task automatic wr_ctrl(input logic [31:0] v); drive(0, 0, 1, v, 0, '0); endtask
  task automatic wr_stat(input logic [31:0] v); drive(0, 0, 0, '0, 1, v); endtask
  task automatic pulse_done(); drive(1, 0, 0, '0, 0, '0); endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 ctrl reset", ctrl_rdata_o, 32'h0001_0000);
    check("R1 status reset", stat_rdata_o, 32'h0);
    check("R1 irq reset", {31'h0, irq_o}, 32'h0);
    rst_n = 1'b1;
    idle(2);

    // threshold 3, no delay, all flags enabled
    wr_ctrl({8'd0, 8'd3, 16'h7001});
    repeat (3) pulse_done();
    idle(2);
    wr_stat(32'h0000_1000);
    idle(2);

    // threshold 0 behaves like 1
    wr_ctrl({8'd0, 8'd0, 16'h7001});
    repeat (2) pulse_done();
    wr_stat(32'h0000_1000);

    // delay timer expiry after a single completion
    wr_ctrl({8'd5, 8'd3, 16'h7001});
    pulse_done();
    idle(30);
    wr_stat(32'h0000_2000);

    // completion periods sweeping across the expiry point
    for (int per = 16; per <= 24; per++) begin
      repeat (4) begin
        pulse_done();
        idle(per - 2);
      end
    end
    idle(30);
    n_chk++;
    if (coinc_seen == 0) begin
      n_bad++;
      $display("FAIL R7: actual coincidences %0d expected at least 1", coinc_seen);
    end

    // load together with a completion
    pulse_done();
    drive(1, 0, 1, {8'd5, 8'd4, 16'h7001}, 0, '0);
    idle(3);

    // error flag, and an event during a clear of the same flag
    drive(0, 1, 0, '0, 0, '0);
    drive(0, 1, 0, '0, 1, 32'h0000_4000);
    idle(2);
    wr_stat(32'hA5A5_8FFF);
    wr_stat(32'h0000_7000);

    // masked flag keeps irq low until enabled
    wr_ctrl({8'd0, 8'd1, 16'h0001});
    pulse_done();
    idle(3);
    wr_ctrl({8'd0, 8'd1, 16'h1000});
    idle(3);
    wr_stat(32'h0000_7000);
    idle(3);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #800000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule